// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the software-visible state of one general-purpose I/O port of up to eight pins. Software writes an output latch that drives the pads. It can write the whole latch at once, or change single bits through three alias addresses. On those aliases a 1 in the write data sets, clears or toggles the matching latch bit. A 0 leaves that bit alone. No read-modify-write is needed to change one bit.

Reading the data address returns the latch and never the pad level. Software can therefore build a new value from the read even when some pins on the port are inputs. A separate read-only address returns the pad levels after a two-flop synchronizer. Two configuration registers hold a per-pin output enable and a per-pin input buffer disable.

A per-pin override input comes from a timer or PWM peripheral. It marks pins used as start or stop inputs to that peripheral, and it forces their output buffers off whatever the configuration says. The bus is a plain synchronous interface. A write takes effect on the clock edge where the write enable is high. Read data follows the address combinationally.

Top module: `gpio_port_regs`

## Requirements
- R1: A write to offset 0x00 loads the output latch (driven on `pad_out`) with write data bits [PINS-1:0] on that clock edge.
- R2: Reads of offsets 0x00, 0x04, 0x08 and 0x0C return the output latch in bits [PINS-1:0], not the pad level. Upper bits read 0.
- R3: A write to offset 0x04 sets each latch bit whose write data bit is 1. The other latch bits keep their value.
- R4: A write to offset 0x08 clears each latch bit whose write data bit is 1. The other latch bits keep their value.
- R5: A write to offset 0x0C inverts each latch bit whose write data bit is 1. The other latch bits keep their value.
- R6: A read of offset 0x10 returns `pad_in` as it stood two clock edges earlier. A value applied after one edge is not yet visible. Writes to 0x10 change no register.
- R7: Offset 0x14 holds per-pin output enable bits and reads them back. `pad_oe[i]` is that bit, except that it is 0 whenever `periph_hold[i]` is 1.
- R8: Offset 0x18 holds per-pin input disable bits (1 = disabled) and reads them back. `pad_ie[i]` is the inverse of that bit. The bit at 0x10 for a disabled pin reads 0.
- R9: Any other address reads 0 and ignores writes. This covers 0x1C and above, and addresses that are not a multiple of 4.
- R10: After reset the latch is 0, all output enables are 0, all input buffers are enabled, and the synchronized pin state is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Byte address of the register |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| pad_in | input | PINS | Raw pad levels |
| periph_hold | input | PINS | Per-pin peripheral input override, forces output buffer off |
| pad_out | output | PINS | Output latch value to the pads |
| pad_oe | output | PINS | Output buffer enable per pin |
| pad_ie | output | PINS | Input buffer enable per pin |

## Verification
The bench drives pad levels that differ from the latch and then reads the data address. A design that returns pads instead of the latch fails there. It applies the set, clear and invert aliases to patterns with both 1 and 0 in the mask. Corrupting an unmasked bit, or treating invert as set, shows on `pad_out`.

The bench samples pin state one and two edges after a pad change. A missing or extra synchronizer stage shows up in those reads. It also writes to the read-only and unmapped addresses, including a misaligned one, and then reads back every register. A loose decode corrupts one of them. Last, it raises the override on pins with output enable set, and a design that ignores the override still drives those pins.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS = 8,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] periph_hold,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_ie
);
  localparam logic [AW-1:0] A_DATA = AW'(5'h00);
  localparam logic [AW-1:0] A_SET  = AW'(5'h04);
  localparam logic [AW-1:0] A_CLR  = AW'(5'h08);
  localparam logic [AW-1:0] A_INV  = AW'(5'h0C);
  localparam logic [AW-1:0] A_PIN  = AW'(5'h10);
  localparam logic [AW-1:0] A_OEN  = AW'(5'h14);
  localparam logic [AW-1:0] A_IDIS = AW'(5'h18);

  logic [PINS-1:0] latch_q, oen_q, idis_q, sync1_q, sync2_q, pin_state, rd_bits;
  logic [PINS-1:0] wd;

  assign wd = reg_wdata[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      oen_q   <= '0;
      idis_q  <= '0;
    end else if (reg_we) begin
      unique case (reg_addr)
        A_DATA:  latch_q <= wd;
        A_SET:   latch_q <= latch_q | wd;
        A_CLR:   latch_q <= latch_q & ~wd;
        A_INV:   latch_q <= latch_q ^ wd;
        A_OEN:   oen_q   <= wd;
        A_IDIS:  idis_q  <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_state = sync2_q & ~idis_q;

  always_comb begin
    unique case (reg_addr)
      A_DATA, A_SET, A_CLR, A_INV: rd_bits = latch_q;
      A_PIN:   rd_bits = pin_state;
      A_OEN:   rd_bits = oen_q;
      A_IDIS:  rd_bits = idis_q;
      default: rd_bits = '0;
    endcase
  end

  assign reg_rdata = DW'(rd_bits);
  assign pad_out   = latch_q;
  assign pad_oe    = oen_q & ~periph_hold;
  assign pad_ie    = ~idis_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int PINS = 8,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_we,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic [PINS-1:0] periph_hold,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_ie
);
  logic latch_wr;
  assign latch_wr = reg_we && (reg_addr == AW'(5'h00) || reg_addr == AW'(5'h04) ||
                               reg_addr == AW'(5'h08) || reg_addr == AW'(5'h0C));

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(5'h00)) |=> pad_out == $past(reg_wdata[PINS-1:0])); // R1
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(5'h04)) |=> pad_out == ($past(pad_out) | $past(reg_wdata[PINS-1:0]))); // R3
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(5'h08)) |=> pad_out == ($past(pad_out) & ~$past(reg_wdata[PINS-1:0]))); // R4
  AST_INV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(5'h0C)) |=> pad_out == ($past(pad_out) ^ $past(reg_wdata[PINS-1:0]))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr |=> $stable(pad_out)); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & periph_hold) == '0); // R7
  AST_DIS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(5'h10)) |-> (reg_rdata[PINS-1:0] & ~pad_ie) == '0); // R8
  AST_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(5'h04)) |-> reg_rdata == DW'(pad_out)); // R2
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PINS(PINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_hold(periph_hold),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 8;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [PINS-1:0] pad_in = '0, periph_hold = '0, pad_out, pad_oe, pad_ie;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs #(.PINS(PINS), .AW(AW), .DW(DW)) u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .periph_hold(periph_hold), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie));

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R10 pad_out", DW'(pad_out), 0);
    chk("R10 pad_oe", DW'(pad_oe), 0);
    chk("R10 pad_ie", DW'(pad_ie), DW'({PINS{1'b1}}));
    rd(5'h10, v); chk("R10 pin state", v, 0);
  endtask

  task automatic t_data();
    logic [DW-1:0] v;
    wr(5'h00, 32'hFFFF_FF3C);
    chk("R1 data load", DW'(pad_out), 32'h3C);
    pad_in = 8'hC3; @(negedge clk); @(negedge clk); @(negedge clk);
    rd(5'h00, v); chk("R2 data reads latch", v, 32'h3C);
    rd(5'h0C, v); chk("R2 alias reads latch", v, 32'h3C);
  endtask

  task automatic t_alias();
    wr(5'h00, 32'h0F);
    wr(5'h04, 32'h30);
    chk("R3 set", DW'(pad_out), 32'h3F);
    wr(5'h04, 32'h00);
    chk("R3 set zero mask", DW'(pad_out), 32'h3F);
    wr(5'h08, 32'h05);
    chk("R4 clear", DW'(pad_out), 32'h3A);
    wr(5'h08, 32'h00);
    chk("R4 clear zero mask", DW'(pad_out), 32'h3A);
    wr(5'h0C, 32'hC3);
    chk("R5 invert", DW'(pad_out), 32'hF9);
    wr(5'h0C, 32'hC3);
    chk("R5 invert back", DW'(pad_out), 32'h3A);
  endtask

  task automatic t_state();
    logic [DW-1:0] v;
    @(negedge clk); pad_in = 8'h00;
    @(negedge clk); @(negedge clk); @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    rd(5'h10, v); chk("R6 one edge lag", v, 0);
    @(negedge clk);
    rd(5'h10, v); chk("R6 two edge visible", v, 32'hA5);
    wr(5'h10, 32'hFF);
    chk("R6 write ignored latch", DW'(pad_out), 32'h3A);
    rd(5'h10, v); chk("R6 write ignored state", v, 32'hA5);
    rd(5'h14, v); chk("R6 write ignored cfg", v, 0);
  endtask

  task automatic t_oe();
    logic [DW-1:0] v;
    wr(5'h14, 32'hF0);
    rd(5'h14, v); chk("R7 cfg readback", v, 32'hF0);
    chk("R7 oe follows cfg", DW'(pad_oe), 32'hF0);
    periph_hold = 8'h30; #1;
    chk("R7 override forces off", DW'(pad_oe), 32'hC0);
    periph_hold = 8'h00; #1;
    chk("R7 override released", DW'(pad_oe), 32'hF0);
  endtask

  task automatic t_ibuf();
    logic [DW-1:0] v;
    wr(5'h18, 32'h0F);
    rd(5'h18, v); chk("R8 cfg2 readback", v, 32'h0F);
    chk("R8 pad_ie", DW'(pad_ie), 32'hF0);
    rd(5'h10, v); chk("R8 disabled reads 0", v, 32'hA0);
    wr(5'h18, 32'h00);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    wr(5'h1C, 32'hFF);
    wr(5'h01, 32'hFF);
    wr(5'h06, 32'h00);
    chk("R9 latch untouched", DW'(pad_out), 32'h3A);
    rd(5'h14, v); chk("R9 cfg untouched", v, 32'hF0);
    rd(5'h18, v); chk("R9 cfg2 untouched", v, 0);
    rd(5'h1C, v); chk("R9 read 0x1C", v, 0);
    rd(5'h01, v); chk("R9 read misaligned", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_alias();
    t_state();
    t_oe();
    t_ibuf();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule